// File: doc/BRIEF.md
# Block-Streaming Gram-Schmidt Orthogonalization Cell

This cell removes from an input vector its component along a given basis vector. It is one tile of a two-dimensional orthogonalization array. Two complex sample streams enter side by side on one valid signal: a basis vector `q`, which has already been normalized upstream, and an input vector `v`. A strobe on the first sample marks the start of each block of `BLK` samples. Over one block the cell accumulates the conjugated inner product `c = sum(conj(q) * v)`. It then replays the stored block and emits `v - c*q` sample by sample. Each replayed `q` sample is sent out unchanged beside its residual, so the next cell in the row can use it. The residual has no final normalization, so a main-beam residual can be taken straight from the output.

Storage is split into two banks. While one block is replayed from one bank, the next block is written into the other. A new block can therefore start in the clock cycle right after the last sample of the previous one. `BLK` must be a power of two, and its default is 128. Samples have signed real and imaginary parts of `DW` bits. `q` uses `DW-1` fraction bits.

Top module: `gs_orth_cell`

## Requirements
- R1: After reset, `out_valid`, `out_strobe`, `busy` and `err` are all 0.
- R2: For each block the cell computes `c_re = sum(qr*vr + qi*vi)` and `c_im = sum(qr*vi - qi*vr)` exactly, with no overflow. Each output is `vo = v - ((c*q) >>> (2*DW-2))`, computed per component with a complex product and a floor shift. `vo` is paired with the `v` sample at the same position in the block.
- R3: `qo_re`/`qo_im` carry the stored `q` sample of the same position, unchanged.
- R4: If the last sample of a block is taken at clock edge L, output sample j is presented after edge L+1+j, for j = 0..BLK-1. `out_valid` is high for those BLK consecutive cycles. `out_strobe` is high only with sample 0.
- R5: A new block may begin in the cycle right after the previous block's last sample. Both blocks are processed correctly, and their outputs follow each other with no gap.
- R6: A strobe that arrives while a block is only partly received discards the partial block and sets `err`. `err` stays 1 until reset. The strobe sample becomes sample 0 of a new block.
- R7: Valid samples without a strobe, arriving while no block is open, are ignored. They leave `busy` at 0 and produce no output.
- R8: Each residual component is saturated to the signed `DW`-bit range.
- R9: `busy` is 1 while a block is open for input or a replay is in progress, and 0 when the cell is idle.
- R10: Input samples may come with idle cycles (`in_valid` low) between them. The result is the same as for unbroken input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample present |
| in_strobe | input | 1 | Marks the first sample of a block |
| q_re | input | DW | Basis sample, real part |
| q_im | input | DW | Basis sample, imaginary part |
| v_re | input | DW | Input-vector sample, real part |
| v_im | input | DW | Input-vector sample, imaginary part |
| out_valid | output | 1 | Output sample present |
| out_strobe | output | 1 | First sample of an output block |
| qo_re | output | DW | Forwarded basis, real part |
| qo_im | output | DW | Forwarded basis, imaginary part |
| vo_re | output | DW | Residual, real part |
| vo_im | output | DW | Residual, imaginary part |
| busy | output | 1 | Block open or replay running |
| err | output | 1 | Sticky short-block flag |

## Verification
Two events can fall on the same clock edge: capturing the final sample of one block, which swaps banks and loads a new coefficient, and replaying the final sample of the block before it. The bench provokes this by driving blocks back to back with no idle cycle between them. Every expected output carries the cycle in which it must appear, so any slip, gap or overlap at the handover shows up as a cycle mismatch. A wrong coefficient or wrong bank shows up as a data mismatch.

// File: rtl/gs_orth_cell.sv
module gs_orth_cell #(
  parameter int DW  = 16,
  parameter int BLK = 128
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_strobe,
  input  logic signed [DW-1:0] q_re,
  input  logic signed [DW-1:0] q_im,
  input  logic signed [DW-1:0] v_re,
  input  logic signed [DW-1:0] v_im,
  output logic                 out_valid,
  output logic                 out_strobe,
  output logic signed [DW-1:0] qo_re,
  output logic signed [DW-1:0] qo_im,
  output logic signed [DW-1:0] vo_re,
  output logic signed [DW-1:0] vo_im,
  output logic                 busy,
  output logic                 err
);

  localparam int AW  = (BLK > 1) ? $clog2(BLK) : 1;
  localparam int ACW = 2*DW + AW + 1;
  localparam int PW  = ACW + DW + 1;
  localparam int RW  = PW + 1;
  localparam int SH  = 2*DW - 2;
  localparam int WW  = 4*DW;
  localparam logic signed [RW-1:0] HI = RW'(2**(DW-1) - 1);
  localparam logic signed [RW-1:0] LO = ~HI;

  logic [WW-1:0] mem [2*BLK];

  logic                  wr_open, wr_bank, rd_bank, rd_act;
  logic [AW-1:0]         wr_cnt, rd_idx;
  logic signed [ACW-1:0] acc_re, acc_im, c_re, c_im;

  wire           start = in_valid & in_strobe;
  wire           take  = in_valid & (in_strobe | wr_open);
  wire           abort = start & wr_open;
  wire [AW-1:0]  widx  = start ? '0 : wr_cnt;
  wire           last  = take & (widx == AW'(BLK-1));

  logic signed [ACW-1:0] ip_re, ip_im, acc_re_n, acc_im_n;
  assign ip_re = ACW'(q_re)*ACW'(v_re) + ACW'(q_im)*ACW'(v_im);
  assign ip_im = ACW'(q_re)*ACW'(v_im) - ACW'(q_im)*ACW'(v_re);
  assign acc_re_n = (start ? '0 : acc_re) + ip_re;
  assign acc_im_n = (start ? '0 : acc_im) + ip_im;

  always_ff @(posedge clk)
    if (take) mem[{wr_bank, widx}] <= {q_re, q_im, v_re, v_im};

  wire [WW-1:0] rw = mem[{rd_bank, rd_idx}];
  logic signed [DW-1:0] rq_re, rq_im, rv_re, rv_im;
  assign rq_re = rw[4*DW-1:3*DW];
  assign rq_im = rw[3*DW-1:2*DW];
  assign rv_re = rw[2*DW-1:DW];
  assign rv_im = rw[DW-1:0];

  logic signed [PW-1:0] pr_re, pr_im;
  logic signed [RW-1:0] res_re, res_im;
  assign pr_re  = PW'(c_re)*PW'(rq_re) - PW'(c_im)*PW'(rq_im);
  assign pr_im  = PW'(c_re)*PW'(rq_im) + PW'(c_im)*PW'(rq_re);
  assign res_re = RW'(rv_re) - RW'(pr_re >>> SH);
  assign res_im = RW'(rv_im) - RW'(pr_im >>> SH);

  function automatic logic signed [DW-1:0] sat(input logic signed [RW-1:0] x);
    if (x > HI)      return DW'(HI);
    else if (x < LO) return DW'(LO);
    else             return x[DW-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_open <= 1'b0; wr_bank <= 1'b0; wr_cnt <= '0;
      rd_bank <= 1'b0; rd_act  <= 1'b0; rd_idx <= '0;
      acc_re  <= '0;   acc_im  <= '0;
      c_re    <= '0;   c_im    <= '0;
      err     <= 1'b0;
    end else begin
      if (abort) err <= 1'b1;
      if (take) begin
        wr_open <= ~last;
        wr_cnt  <= widx + AW'(1);
        acc_re  <= acc_re_n;
        acc_im  <= acc_im_n;
      end
      if (last) begin
        c_re    <= acc_re_n;
        c_im    <= acc_im_n;
        wr_bank <= ~wr_bank;
        rd_bank <= wr_bank;
        rd_act  <= 1'b1;
        rd_idx  <= '0;
      end else if (rd_act) begin
        rd_idx <= rd_idx + AW'(1);
        if (rd_idx == AW'(BLK-1)) rd_act <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_strobe <= 1'b0;
      qo_re <= '0; qo_im <= '0; vo_re <= '0; vo_im <= '0;
    end else begin
      out_valid  <= rd_act;
      out_strobe <= rd_act & (rd_idx == '0);
      if (rd_act) begin
        qo_re <= rq_re;
        qo_im <= rq_im;
        vo_re <= sat(res_re);
        vo_im <= sat(res_im);
      end
    end
  end

  assign busy = rd_act | wr_open;

  AST_STROBE_IN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_strobe |-> out_valid);                                          // R4
  AST_BLOCK_OPENS_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_strobe);                                   // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);                                                       // R6
  AST_ERR_ON_EARLY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(in_valid && in_strobe && busy));               // R6

endmodule

// File: tb/tb_gs_orth_cell.sv
module tb_gs_orth_cell;
  localparam int CLK_P = 10;
  localparam int DW    = 16;
  localparam int BLK   = 8;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_strobe = 0;
  logic signed [DW-1:0] q_re = 0, q_im = 0, v_re = 0, v_im = 0;
  logic out_valid, out_strobe, busy, err;
  logic signed [DW-1:0] qo_re, qo_im, vo_re, vo_im;

  gs_orth_cell #(.DW(DW), .BLK(BLK)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_strobe(in_strobe),
    .q_re(q_re), .q_im(q_im), .v_re(v_re), .v_im(v_im),
    .out_valid(out_valid), .out_strobe(out_strobe),
    .qo_re(qo_re), .qo_im(qo_im), .vo_re(vo_re), .vo_im(vo_im),
    .busy(busy), .err(err));

  always #(CLK_P/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct {
    bit strobe; int qr, qi, vr, vi; int at; string tag;
  } item_t;
  item_t sb[$];

  int aq_r[BLK], aq_i[BLK], av_r[BLK], av_i[BLK];

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int sat(longint x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return int'(x);
  endfunction

  task automatic drive(bit vl, bit st, int a, int b, int c, int d);
    @(negedge clk);
    in_valid = vl; in_strobe = st;
    q_re = DW'(a); q_im = DW'(b); v_re = DW'(c); v_im = DW'(d);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0);
  endtask

  task automatic run_block(int kind, string tag, bit gap);
    longint cr = 0, ci = 0;
    int c0 = 0;
    for (int i = 0; i < BLK; i++) begin
      if (kind == 1) begin
        aq_r[i] = 32767; aq_i[i] = 0;
        av_r[i] = (i == 0) ? -32768 : 32767; av_i[i] = 0;
      end else begin
        aq_r[i] = int'($urandom_range(0, 24000)) - 12000;
        aq_i[i] = int'($urandom_range(0, 24000)) - 12000;
        av_r[i] = int'($urandom_range(0, 40000)) - 20000;
        av_i[i] = int'($urandom_range(0, 40000)) - 20000;
      end
      cr += longint'(aq_r[i])*av_r[i] + longint'(aq_i[i])*av_i[i];
      ci += longint'(aq_r[i])*av_i[i] - longint'(aq_i[i])*av_r[i];
    end
    for (int i = 0; i < BLK; i++) begin
      if (gap && (i % 2 == 1)) idle(1 + i % 3);
      drive(1, i == 0, aq_r[i], aq_i[i], av_r[i], av_i[i]);
      if (i == BLK - 1) c0 = cyc;
    end
    for (int j = 0; j < BLK; j++) begin
      item_t it;
      longint pr, pi;
      pr = cr*aq_r[j] - ci*aq_i[j];
      pi = cr*aq_i[j] + ci*aq_r[j];
      it.strobe = (j == 0);
      it.qr = aq_r[j]; it.qi = aq_i[j];
      it.vr = sat(longint'(av_r[j]) - (pr >>> 30));
      it.vi = sat(longint'(av_i[j]) - (pi >>> 30));
      it.at = c0 + 2 + j;
      it.tag = tag;
      sb.push_back(it);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        chk(0, "R7", "unexpected output", 1, 0);
      end else begin
        item_t e;
        e = sb.pop_front();
        chk(cyc == e.at, "R4/R5", {e.tag, " output cycle"}, cyc, e.at);
        chk(out_strobe == e.strobe, "R4", {e.tag, " out_strobe"}, out_strobe, e.strobe);
        chk(qo_re == e.qr && qo_im == e.qi, "R3", {e.tag, " q forward re"}, qo_re, e.qr);
        chk(vo_re == e.vr, e.tag, "residual re", vo_re, e.vr);
        chk(vo_im == e.vi, e.tag, "residual im", vo_im, e.vi);
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      failures++;
      $display("FAIL R5 watchdog expired actual=%0d expected=%0d", cyc, 0);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0 && out_strobe == 0, "R1", "outputs after reset", out_valid, 0);
    chk(busy == 0, "R1", "busy after reset", busy, 0);
    chk(err == 0, "R1", "err after reset", err, 0);

    // R7: samples without a strobe while idle
    drive(1, 0, 100, 200, 300, 400);
    drive(1, 0, 5, 6, 7, 8);
    idle(1);
    chk(busy == 0, "R7", "busy after strobeless samples", busy, 0);
    idle(3);

    // R2 single block, R9 busy during replay
    run_block(0, "R2", 0);
    idle(1);
    chk(busy == 1, "R9", "busy during replay", busy, 1);
    idle(BLK + 3);
    chk(busy == 0, "R9", "busy when idle", busy, 0);

    // R5 back-to-back blocks
    run_block(0, "R5", 0);
    run_block(0, "R5", 0);
    run_block(0, "R5", 0);
    idle(BLK + 3);

    // R10 gappy input
    run_block(0, "R10", 1);
    idle(BLK + 3);

    // R6 short block then a full one
    chk(err == 0, "R6", "err before short block", err, 0);
    drive(1, 1, 1, 2, 3, 4);
    drive(1, 0, 1, 2, 3, 4);
    drive(1, 0, 1, 2, 3, 4);
    run_block(0, "R6", 0);
    idle(1);
    chk(err == 1, "R6", "err after short block", err, 1);
    idle(BLK + 3);

    // R8 saturation
    run_block(1, "R8", 0);
    idle(BLK + 4);
    chk(err == 1, "R6", "err stays set", err, 1);
    chk(sb.size() == 0, "R5", "outputs left pending", sb.size(), 0);
    finish_run();
  end
endmodule